// File: doc/BRIEF.md
# Per-CPU Device Interrupt Mask Router

The router keeps one shared vector of device interrupt requests and, for each of up to four processors, a private mask of the same width. For every processor it continuously presents the masked result vector (mask AND request) and drives a level interrupt line that is high whenever any result bit is set. Devices raise and drop individual request lines through set and clear pulse vectors. Software reaches the masks, the results and the request vector through a single-cycle register port.

Whenever a mask write or a request change makes a result bit rise, the router emits a one-cycle post strobe for that processor and bit. Whenever one makes a result bit fall, it emits a one-cycle clear strobe. Bits whose result does not move produce no strobe, so a downstream interrupt controller sees exactly the edges of each processor's result. The register port has no back-pressure: an access presented with `reg_valid` high is taken in that cycle, write effects land on the next clock edge, and read data and the error flag are valid in the same cycle with no wait state.

Top module: `irq_mask_router`

## Requirements
- R1: For each processor c, `cpu_result` slice c equals mask c AND the request vector, as held in registers after the latest clock edge. The same value is returned when the result register of processor c is read.
- R2: After a mask write, a post strobe pulses for one cycle for every bit whose result goes from 0 to 1. This happens for exactly those bits where the mask bit changed, the new mask bit is 1 and the request bit is 1. The strobe appears in the cycle after the write edge.
- R3: After a mask write, a clear strobe pulses for one cycle for every bit whose result goes from 1 to 0 because its mask bit was turned off. No strobe fires for a bit whose mask did not change.
- R4: A bit set in `line_set` is set in the request vector at the next edge. Every processor whose mask has that bit set and whose result bit was 0 gets a post strobe. Re-asserting a line that is already set produces no strobe. When the same bit is both set and cleared in one cycle, the set wins.
- R5: A bit set in `line_clr` that is set in the request vector is removed at the next edge. Every processor whose result had that bit gets a clear strobe. Clearing a line that is not set is spurious: it changes no state and produces no strobe.
- R6: Address map on the 12-bit offset. With bit 11 = 1, the access is the banked mask alias of processor `addr[9:4]`. With bit 11 = 0 and bit 10 = 1, it is the banked result alias of processor `addr[9:4]`. Otherwise the register slot is `addr[9:6]`, on a 64-byte stride: slots 0 to 3 are the masks of processors 0 to 3, slots 4 to 7 are their results, and slot 8 is the request vector. `addr[3:0]` must be zero.
- R7: `reg_size` gives the access size as log2 of the byte count. Only the value 3 (8 bytes) is legal. Any other size raises `reg_err`, leaves every register unchanged and reads as zero.
- R8: These accesses raise `reg_err`, change nothing and read as zero: writes to a result or to the request vector, accesses to an unmapped slot, a processor index at or above the processor count, and a nonzero `addr[3:0]`.
- R9: `cpu_irq[c]` is the OR of processor c's result vector, registered. It follows the result one clock edge later.
- R10: After reset, all masks, the request vector, all strobes and all interrupt lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access present this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the access |
| reg_size | input | 2 | log2 of access size in bytes |
| reg_wdata | input | NLINES | Write data |
| reg_rdata | output | NLINES | Read data, same cycle |
| reg_err | output | 1 | Access rejected, same cycle |
| line_set | input | NLINES | Per-line request assert pulses |
| line_clr | input | NLINES | Per-line request deassert pulses |
| cpu_result | output | NCPU*NLINES | Masked result vectors, processor c at slice c |
| cpu_irq | output | NCPU | Per-processor level interrupt |
| post_evt | output | NCPU*NLINES | One-cycle post strobes per processor and bit |
| clear_evt | output | NCPU*NLINES | One-cycle clear strobes per processor and bit |

## Verification
The bench builds the router with four processors and 64 request lines, the full default. With these values every strided mask and result slot is populated, a banked index of 4 or more falls outside the processor range, and the top line (bit 63) can be exercised. The stimulus mixes mask writes, line assertions and clears across all four processors. It uses a bench-side model of the masks and the request vector to predict each strobe and each interrupt level.

// File: rtl/irqrt_pkg.sv
package irqrt_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_MASK = 2'd1,
    TGT_RES  = 2'd2,
    TGT_REQ  = 2'd3
  } tgt_e;

  localparam int          ADDR_W     = 12;
  localparam logic [1:0]  SIZE_FULL  = 2'd3;
  localparam logic [3:0]  SLOT_RES0  = 4'd4;
  localparam logic [3:0]  SLOT_REQ   = 4'd8;
  localparam int          MAX_CPU    = 4;
endpackage

// File: rtl/irqrt_decode.sv
module irqrt_decode
  import irqrt_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output tgt_e              tgt_o,
  output logic [CPU_W-1:0]  cpu_o,
  output logic              ok_o,
  output logic              err_o,
  output logic [NCPU-1:0]   wr_mask_o
);
  localparam logic [5:0] NCPU6 = 6'(NCPU);

  logic [3:0] slot;
  logic [5:0] idx;
  logic       in_range;
  logic       bad;

  assign slot = addr_i[9:6];

  always_comb begin
    tgt_o = TGT_NONE;
    idx   = '0;
    if (addr_i[11]) begin
      tgt_o = TGT_MASK;
      idx   = addr_i[9:4];
    end else if (addr_i[10]) begin
      tgt_o = TGT_RES;
      idx   = addr_i[9:4];
    end else if (slot < SLOT_RES0) begin
      tgt_o = TGT_MASK;
      idx   = {2'b00, slot};
    end else if (slot < SLOT_REQ) begin
      tgt_o = TGT_RES;
      idx   = {2'b00, slot - SLOT_RES0};
    end else if (slot == SLOT_REQ) begin
      tgt_o = TGT_REQ;
    end
  end

  assign in_range = (tgt_o == TGT_REQ) || (idx < NCPU6);
  assign bad = (size_i != SIZE_FULL) || (tgt_o == TGT_NONE) || !in_range
             || (addr_i[3:0] != 4'd0) || (write_i && tgt_o != TGT_MASK);
  assign err_o = valid_i && bad;
  assign ok_o  = valid_i && !bad;
  assign cpu_o = idx[CPU_W-1:0];

  for (genvar c = 0; c < NCPU; c++) begin : g_wr
    assign wr_mask_o[c] = ok_o && write_i && (tgt_o == TGT_MASK) && (idx == 6'(c));
  end

  always_comb begin
    if (valid_i && size_i != SIZE_FULL) begin
      a_narrow_rejected_r7: assert (err_o && wr_mask_o == '0);
    end
    if (valid_i && write_i && tgt_o != TGT_MASK) begin
      a_readonly_write_r8: assert (wr_mask_o == '0);
    end
  end
endmodule

// File: rtl/irqrt_reqvec.sv
module irqrt_reqvec #(
  parameter int NLINES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] set_i,
  input  logic [NLINES-1:0] clr_i,
  output logic [NLINES-1:0] req_q,
  output logic [NLINES-1:0] req_n
);
  assign req_n = (req_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_n;
  end

  p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((req_q & $past(set_i)) == $past(set_i)));

  p_spurious_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((req_q & $past(clr_i & ~req_q & ~set_i)) == '0));
endmodule

// File: rtl/irqrt_lane.sv
module irqrt_lane #(
  parameter int NLINES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NLINES-1:0] wdata,
  input  logic [NLINES-1:0] req_q,
  input  logic [NLINES-1:0] req_n,
  output logic [NLINES-1:0] mask_o,
  output logic [NLINES-1:0] res_o,
  output logic [NLINES-1:0] post_o,
  output logic [NLINES-1:0] clr_o,
  output logic              irq_o
);
  logic [NLINES-1:0] mask_n;
  logic [NLINES-1:0] res_n;

  assign mask_n = wr_en ? wdata : mask_o;
  assign res_o  = mask_o & req_q;
  assign res_n  = mask_n & req_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      post_o <= '0;
      clr_o  <= '0;
      irq_o  <= 1'b0;
    end else begin
      mask_o <= mask_n;
      post_o <= res_n & ~res_o;
      clr_o  <= res_o & ~res_n;
      irq_o  <= |res_o;
    end
  end

  p_post_means_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (post_o != '0) |-> ((post_o & ~res_o) == '0));

  p_clear_means_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> ((clr_o & res_o) == '0));

  p_irq_rises_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_o != '0) |=> irq_o);

  p_irq_falls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_o == '0) |=> !irq_o);
endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irqrt_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int NLINES = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_valid,
  input  logic                     reg_write,
  input  logic [11:0]              reg_addr,
  input  logic [1:0]               reg_size,
  input  logic [NLINES-1:0]        reg_wdata,
  output logic [NLINES-1:0]        reg_rdata,
  output logic                     reg_err,
  input  logic [NLINES-1:0]        line_set,
  input  logic [NLINES-1:0]        line_clr,
  output logic [NCPU*NLINES-1:0]   cpu_result,
  output logic [NCPU-1:0]          cpu_irq,
  output logic [NCPU*NLINES-1:0]   post_evt,
  output logic [NCPU*NLINES-1:0]   clear_evt
);
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

  tgt_e              tgt;
  logic [CPU_W-1:0]  cpu_sel;
  logic              acc_ok;
  logic [NCPU-1:0]   wr_mask;
  logic [NLINES-1:0] req_q;
  logic [NLINES-1:0] req_n;
  logic [NLINES-1:0] mask_arr [NCPU];
  logic [NLINES-1:0] res_arr  [NCPU];
  logic [NCPU*NLINES-1:0] mask_flat;

  irqrt_decode #(.NCPU(NCPU), .CPU_W(CPU_W)) u_dec (
    .valid_i   (reg_valid),
    .write_i   (reg_write),
    .addr_i    (reg_addr),
    .size_i    (reg_size),
    .tgt_o     (tgt),
    .cpu_o     (cpu_sel),
    .ok_o      (acc_ok),
    .err_o     (reg_err),
    .wr_mask_o (wr_mask)
  );

  irqrt_reqvec #(.NLINES(NLINES)) u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (line_set),
    .clr_i (line_clr),
    .req_q (req_q),
    .req_n (req_n)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_lane
    irqrt_lane #(.NLINES(NLINES)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_mask[c]),
      .wdata  (reg_wdata),
      .req_q  (req_q),
      .req_n  (req_n),
      .mask_o (mask_arr[c]),
      .res_o  (res_arr[c]),
      .post_o (post_evt[c*NLINES +: NLINES]),
      .clr_o  (clear_evt[c*NLINES +: NLINES]),
      .irq_o  (cpu_irq[c])
    );
    assign cpu_result[c*NLINES +: NLINES] = res_arr[c];
    assign mask_flat[c*NLINES +: NLINES]  = mask_arr[c];
  end

  always_comb begin
    reg_rdata = '0;
    if (acc_ok && !reg_write) begin
      case (tgt)
        TGT_MASK: reg_rdata = mask_arr[cpu_sel];
        TGT_RES:  reg_rdata = res_arr[cpu_sel];
        TGT_REQ:  reg_rdata = req_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

  p_rejected_write_keeps_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && reg_err) |=> $stable(mask_flat));

  p_err_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_err) |-> (reg_rdata == '0));
endmodule

// File: tb/sim_irq_mask_router.sv
`timescale 1ns/1ps
module sim_irq_mask_router;
  localparam int NC = 4;
  localparam int NL = 64;
  localparam int NSTEP = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [1:0]  reg_size = 2'd3;
  logic [NL-1:0] reg_wdata = '0, line_set = '0, line_clr = '0;
  logic [NL-1:0] reg_rdata;
  logic reg_err;
  logic [NC*NL-1:0] cpu_result, post_evt, clear_evt;
  logic [NC-1:0] cpu_irq;

  int checks = 0;
  int failures = 0;

  logic [NL-1:0] m_mask [NC];
  logic [NL-1:0] m_req;

  // op[67:66]: 0 mask write, 1 line set, 2 line clear; cpu[65:64]; data[63:0]
  localparam logic [67:0] STEPS [NSTEP] = '{
    {2'd0, 2'd0, 64'h0000_0000_0000_00FF},
    {2'd1, 2'd0, 64'h0000_0000_0000_000F},
    {2'd0, 2'd1, 64'h8000_0000_0000_0003},
    {2'd1, 2'd0, 64'h8000_0000_0000_0000},
    {2'd0, 2'd0, 64'h0000_0000_0000_000C},
    {2'd2, 2'd0, 64'h0000_0000_0000_0004},
    {2'd2, 2'd0, 64'h0000_0000_0000_0100},
    {2'd1, 2'd0, 64'h0000_0000_0000_000F},
    {2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'd0, 2'd2, 64'hAAAA_AAAA_AAAA_AAAA},
    {2'd2, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'd0, 2'd3, 64'h0000_0000_0000_0000}
  };

  irq_mask_router #(.NCPU(NC), .NLINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_err(reg_err), .line_set(line_set),
    .line_clr(line_clr), .cpu_result(cpu_result), .cpu_irq(cpu_irq),
    .post_evt(post_evt), .clear_evt(clear_evt)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] sz,
                    output logic [NL-1:0] d, output logic e);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a; reg_size = sz;
    #1;
    d = reg_rdata; e = reg_err;
    reg_valid = 1'b0; reg_size = 2'd3;
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] sz,
                    input logic [NL-1:0] d, output logic e);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_size = sz; reg_wdata = d;
    #1;
    e = reg_err;
    @(posedge clk); @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; reg_size = 2'd3;
  endtask

  task automatic check_all(input string tag, input logic [NL-1:0] ep [NC],
                           input logic [NL-1:0] ec [NC]);
    for (int c = 0; c < NC; c++) begin
      chk({tag, " R2/R4 post"}, post_evt[c*NL +: NL], ep[c]);
      chk({tag, " R3/R5 clear"}, clear_evt[c*NL +: NL], ec[c]);
      chk({tag, " R1 result"}, cpu_result[c*NL +: NL], m_mask[c] & m_req);
    end
  endtask

  task automatic check_irq(input string tag);
    @(posedge clk); @(negedge clk);
    for (int c = 0; c < NC; c++)
      chk({tag, " R9 irq"}, {63'd0, cpu_irq[c]}, {63'd0, |(m_mask[c] & m_req)});
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [NL-1:0] d, nreq;
    logic [NL-1:0] nmask [NC];
    logic [NL-1:0] ep [NC];
    logic [NL-1:0] ec [NC];
    logic e;
    for (int c = 0; c < NC; c++) m_mask[c] = '0;
    m_req = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 result", cpu_result[NL-1:0] | cpu_result[NL +: NL] | cpu_result[2*NL +: NL] | cpu_result[3*NL +: NL], '0);
    chk("R10 irq", {60'd0, cpu_irq}, '0);
    chk("R10 events", post_evt[NL-1:0] | clear_evt[NL-1:0], '0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h000, 2'd3, d, e); chk("R10 mask0 read", d, '0);
    rd(12'h200, 2'd3, d, e); chk("R10 request read", d, '0);

    // table walk
    for (int s = 0; s < NSTEP; s++) begin
      logic [1:0] op = STEPS[s][67:66];
      logic [1:0] cp = STEPS[s][65:64];
      logic [NL-1:0] dv = STEPS[s][63:0];
      nreq = m_req;
      for (int c = 0; c < NC; c++) nmask[c] = m_mask[c];
      if (op == 2'd0) nmask[cp] = dv;
      if (op == 2'd1) nreq = m_req | dv;
      if (op == 2'd2) nreq = m_req & ~dv;
      for (int c = 0; c < NC; c++) begin
        ep[c] = (nmask[c] & nreq) & ~(m_mask[c] & m_req);
        ec[c] = (m_mask[c] & m_req) & ~(nmask[c] & nreq);
      end
      if (op == 2'd0) begin
        reg_valid = 1'b1; reg_write = 1'b1; reg_size = 2'd3;
        reg_addr = {2'b00, 2'b00, cp, 6'd0}; reg_wdata = dv;
      end else if (op == 2'd1) line_set = dv;
      else line_clr = dv;
      @(posedge clk); @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0; line_set = '0; line_clr = '0;
      m_req = nreq;
      for (int c = 0; c < NC; c++) m_mask[c] = nmask[c];
      check_all($sformatf("step%0d", s), ep, ec);
      check_irq($sformatf("step%0d", s));
    end

    // R7: narrow write ignored, narrow read returns zero
    wr(12'h080, 2'd2, 64'h1234, e);
    chk("R7 narrow write err", {63'd0, e}, 64'd1);
    rd(12'h080, 2'd3, d, e); chk("R7 mask unchanged", d, m_mask[2]);
    rd(12'h080, 2'd1, d, e); chk("R7 narrow read zero", d, '0);
    chk("R7 narrow read err", {63'd0, e}, 64'd1);

    // R8: read-only and unmapped targets
    wr(12'h100, 2'd3, 64'hFFFF, e); chk("R8 result write err", {63'd0, e}, 64'd1);
    wr(12'h200, 2'd3, 64'hFFFF, e); chk("R8 request write err", {63'd0, e}, 64'd1);
    rd(12'h200, 2'd3, d, e); chk("R8 request unchanged", d, m_req);
    rd(12'h240, 2'd3, d, e); chk("R8 unmapped err", {63'd0, e}, 64'd1);
    wr(12'h850, 2'd3, 64'h5, e); chk("R8 cpu out of range err", {63'd0, e}, 64'd1);
    rd(12'h004, 2'd3, d, e); chk("R8 misaligned err", {63'd0, e}, 64'd1);
    for (int c = 0; c < NC; c++) begin
      rd({2'b00, 2'b00, 2'(c), 6'd0}, 2'd3, d, e);
      chk("R8 masks untouched", d, m_mask[c]);
    end

    // R4: set and clear of one line in the same cycle, set wins
    line_set = 64'h20; line_clr = 64'h20;
    @(posedge clk); @(negedge clk);
    line_set = '0; line_clr = '0;
    m_req = m_req | 64'h20;
    chk("R4 set wins post cpu2", post_evt[2*NL +: NL], m_mask[2] & 64'h20);
    rd(12'h200, 2'd3, d, e); chk("R4 set wins request", d, m_req);

    // R6: banked aliases
    wr(12'h820, 2'd3, 64'h0000_0000_0000_0021, e);
    chk("R6 banked write ok", {63'd0, e}, 64'd0);
    m_mask[2] = 64'h21;
    rd(12'h080, 2'd3, d, e); chk("R6 banked mask lands in slot2", d, m_mask[2]);
    rd(12'h420, 2'd3, d, e); chk("R6 banked result cpu2", d, m_mask[2] & m_req);
    rd(12'h180, 2'd3, d, e); chk("R6 strided result cpu2", d, m_mask[2] & m_req);
    rd(12'h830, 2'd3, d, e); chk("R6 banked mask cpu3", d, m_mask[3]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule